// File: doc/BRIEF.md
# Processor Mode and Event Tracker

This block keeps a register with one bit per event class that a processor core may be servicing: emulation, reset, non-maskable interrupt, exception and twelve general interrupts. Entry strobes set bits in it. A return strobe retires the event now being serviced. The bits nest, and a lower index means a higher priority. From the register contents the block derives the privilege level the core runs at: User, Supervisor or Emulation.

The register and the mode both leave the block as outputs. The mode is also used to gate memory-mapped register reads, so a read issued from User mode is refused. When the core leaves reset, the register marks the reset event as being serviced. If the debug hardware caused the reset, the register also marks emulation, so the core comes up in Emulation mode instead of Supervisor mode.

Top module: `evt_mode_tracker`

## Requirements
- R1: While `core_rst` is high at a clock edge, that edge loads `pend` with zero and `mode` with User. Event and return strobes at that edge have no effect.
- R2: At the first edge after `core_rst` falls, `pend` is loaded with 0x0002 (bit 1, the reset event). Strobes at that edge are ignored.
- R3: If `emu_rst_cause` was high at the last edge with `core_rst` high, the exit load is 0x0003 instead. Bit 0 is the emulation event, so the mode becomes Emulation.
- R4: Each high bit of `evt_set` sets the matching `pend` bit at the next edge. Bits already set stay set, so nested events accumulate.
- R5: A return strobe (`evt_ret`) clears the lowest-indexed set bit of `pend`. A set strobe in the same cycle is applied after the clear, so it wins on the same bit.
- R6: A return strobe while `pend` is zero leaves `pend` at zero.
- R7: `mode` is encoded 2'b00 User, 2'b01 Supervisor, 2'b10 Emulation. It is Emulation whenever `pend` bit 0 is set, whatever the other bits hold.
- R8: With bit 0 clear and any other bit set, `mode` is Supervisor. With `pend` all zero, `mode` is User.
- R9: `mode` is registered. It shows the decode of the `pend` value that stood one cycle earlier.
- R10: A read request (`rd_req`) made while `mode` is User, or while `core_rst` is high, is refused. At the next edge `rd_deny` goes high for one cycle and `rd_data` is zero.
- R11: A read request made in Supervisor or Emulation mode returns, at the next edge, the `pend` value seen at request time, with `rd_deny` low. With no request, `rd_data` is zero and `rd_deny` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| core_rst | input | 1 | Synchronous core reset, active high |
| emu_rst_cause | input | 1 | Debug hardware caused the current reset |
| evt_set | input | 16 | Event entry strobes, one per event bit |
| evt_ret | input | 1 | Return-from-event strobe |
| rd_req | input | 1 | Memory-mapped register read request |
| pend | output | 16 | Pending/active event register |
| mode | output | 2 | Privilege mode code |
| rd_data | output | 16 | Read data, zero when refused |
| rd_deny | output | 1 | Read refused, one-cycle pulse per request |

## Verification
The hardest state to reach from the ports is Emulation mode. Only an emulation-caused reset or a bit-0 strobe gets there. Random traffic also seldom reaches deep nesting, where a return must pick the lowest set bit out of many.

The stimulus adds directed sequences for these cases. One sequence releases reset with the cause flag high. Another stacks several interrupts, then returns past an emulation event layered on top. The random phase mixes sparse one-hot strobes, frequent returns, reads, and occasional resets with a random cause flag, so that each mode is entered and left many times.

// File: rtl/evt_mode_pkg.sv
package evt_mode_pkg;
    typedef enum logic [1:0] {
        MODE_USER = 2'b00,
        MODE_SUP  = 2'b01,
        MODE_EMU  = 2'b10
    } mode_e;

    localparam int EVT_BIT_EMU = 0;
    localparam int EVT_BIT_RST = 1;
endpackage

// File: rtl/evt_pend_next.sv
module evt_pend_next #(
    parameter int W = 16
) (
    input  logic [W-1:0] pend_q,
    input  logic [W-1:0] evt_set,
    input  logic         evt_ret,
    input  logic         hold_rst,
    input  logic         exit_rst,
    input  logic         emu_cause,
    output logic [W-1:0] pend_d
);
    import evt_mode_pkg::*;

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] retired;

    always_comb begin
        // retire lowest set bit (the event being serviced); zero stays zero
        retired = evt_ret ? (pend_q & (pend_q - ONE)) : pend_q;
        pend_d  = retired | evt_set;
        if (exit_rst) begin
            pend_d = '0;
            pend_d[EVT_BIT_RST] = 1'b1;
            pend_d[EVT_BIT_EMU] = emu_cause;
        end
        if (hold_rst) begin
            pend_d = '0;
        end
    end
endmodule

// File: rtl/evt_mode_decode.sv
module evt_mode_decode #(
    parameter int W = 16
) (
    input  logic [W-1:0]         pend,
    output evt_mode_pkg::mode_e  mode
);
    import evt_mode_pkg::*;

    always_comb begin
        if (pend[EVT_BIT_EMU]) begin
            mode = MODE_EMU;
        end else if (|pend) begin
            mode = MODE_SUP;
        end else begin
            mode = MODE_USER;
        end
    end
endmodule

// File: rtl/evt_mode_tracker.sv
module evt_mode_tracker #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         core_rst,
    input  logic         emu_rst_cause,
    input  logic [W-1:0] evt_set,
    input  logic         evt_ret,
    input  logic         rd_req,
    output logic [W-1:0] pend,
    output logic [1:0]   mode,
    output logic [W-1:0] rd_data,
    output logic         rd_deny
);
    import evt_mode_pkg::*;

    typedef struct packed {
        logic [W-1:0] pend;
        mode_e        mode;
        logic         in_rst;
        logic         emu_cause;
        logic [W-1:0] rd_data;
        logic         rd_deny;
    } state_t;

    state_t st_q, st_d;
    logic [W-1:0] pend_nxt;
    mode_e        mode_dec;
    logic         read_ok;

    evt_pend_next #(.W(W)) u_next (
        .pend_q    (st_q.pend),
        .evt_set   (evt_set),
        .evt_ret   (evt_ret),
        .hold_rst  (core_rst),
        .exit_rst  (st_q.in_rst),
        .emu_cause (st_q.emu_cause),
        .pend_d    (pend_nxt)
    );

    evt_mode_decode #(.W(W)) u_dec (
        .pend (st_q.pend),
        .mode (mode_dec)
    );

    always_comb begin
        st_d      = st_q;
        read_ok   = !core_rst && (st_q.mode != MODE_USER);
        st_d.pend = pend_nxt;
        st_d.mode = core_rst ? MODE_USER : mode_dec;
        st_d.in_rst = core_rst;
        if (core_rst) begin
            st_d.emu_cause = emu_rst_cause;
        end
        st_d.rd_data = (rd_req && read_ok) ? st_q.pend : '0;
        st_d.rd_deny = rd_req && !read_ok;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pend    = st_q.pend;
    assign mode    = st_q.mode;
    assign rd_data = st_q.rd_data;
    assign rd_deny = st_q.rd_deny;

    // R7
    emu_bit_mode_chk: assert property (@(posedge clk) disable iff (core_rst)
        pend[0] |=> mode == 2'b10);

    // R8
    sup_mode_chk: assert property (@(posedge clk) disable iff (core_rst)
        (!pend[0] && pend != '0) |=> mode == 2'b01);

    // R8
    user_mode_chk: assert property (@(posedge clk) disable iff (core_rst)
        (pend == '0) |=> mode == 2'b00);

    // R10
    user_read_deny_chk: assert property (@(posedge clk) disable iff (core_rst)
        (rd_req && mode == 2'b00) |=> (rd_deny && rd_data == '0));

    // R11
    priv_read_ok_chk: assert property (@(posedge clk) disable iff (core_rst)
        (rd_req && mode != 2'b00) |=> (!rd_deny && rd_data == $past(pend)));

    // R2
    rst_exit_load_chk: assert property (@(posedge clk) disable iff (core_rst)
        st_q.in_rst |=> (pend[1] && pend[W-1:2] == '0));

    // R6
    empty_ret_chk: assert property (@(posedge clk) disable iff (core_rst)
        (evt_ret && pend == '0 && evt_set == '0 && !st_q.in_rst) |=> pend == '0);
endmodule

// File: tb/evt_mode_tracker_bench.sv
`timescale 1ns/1ps
module evt_mode_tracker_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         core_rst = 1'b1;
    logic         emu_rst_cause = 1'b0;
    logic [W-1:0] evt_set = '0;
    logic         evt_ret = 1'b0;
    logic         rd_req = 1'b0;
    logic [W-1:0] pend, rd_data;
    logic [1:0]   mode;
    logic         rd_deny;

    int checks = 0;
    int fails  = 0;

    // bench model
    logic [W-1:0] m_pend = '0;
    logic [1:0]   m_mode = 2'b00;
    logic         m_in_rst = 1'b0;
    logic         m_emu = 1'b0;

    always #2 clk = ~clk;

    evt_mode_tracker #(.W(W)) u_evt_mode_tracker (
        .clk, .core_rst, .emu_rst_cause, .evt_set, .evt_ret, .rd_req,
        .pend, .mode, .rd_data, .rd_deny
    );

    function automatic logic [1:0] decode_f(logic [W-1:0] p);
        if (p[0]) return 2'b10;
        if (p != '0) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [W-1:0] clear_low_f(logic [W-1:0] p);
        for (int i = 0; i < W; i++) begin
            if (p[i]) begin
                p[i] = 1'b0;
                return p;
            end
        end
        return p;
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(logic rst, logic emu, logic [W-1:0] s, logic r, logic rd);
        logic [W-1:0] e_data;
        logic         e_deny;
        logic [W-1:0] n_pend;
        string        ptag, rtag;
        core_rst = rst; emu_rst_cause = emu; evt_set = s; evt_ret = r; rd_req = rd;
        e_deny = rd && (rst || m_mode == 2'b00);
        e_data = (rd && !e_deny) ? m_pend : '0;
        rtag = e_deny ? "R10" : "R11";
        if (rst) begin
            n_pend = '0; ptag = "R1";
        end else if (m_in_rst) begin
            n_pend = m_emu ? 16'h0003 : 16'h0002;
            ptag = m_emu ? "R3" : "R2";
        end else if (r && m_pend == '0 && s == '0) begin
            n_pend = '0; ptag = "R6";
        end else begin
            n_pend = (r ? clear_low_f(m_pend) : m_pend) | s;
            ptag = r ? "R5" : "R4";
        end
        m_mode = rst ? 2'b00 : decode_f(m_pend);
        m_pend = n_pend;
        m_in_rst = rst;
        if (rst) m_emu = emu;
        @(posedge clk);
        @(negedge clk);
        check(ptag, pend, m_pend);
        if (rst) check("R1", {14'd0, mode}, {14'd0, m_mode});
        else if (m_mode == 2'b10) check("R7", {14'd0, mode}, {14'd0, m_mode});
        else check("R8 R9", {14'd0, mode}, {14'd0, m_mode});
        check(rtag, rd_data, e_data);
        check(rtag, {15'd0, rd_deny}, {15'd0, e_deny});
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] s;
        void'($urandom(32'd1234));
        @(negedge clk);
        // R1: held in reset, strobes and reads ignored/refused
        step(1, 0, 16'hFFFF, 1, 1);
        step(1, 0, 16'h00F0, 0, 1);
        // R2: normal exit, strobe in exit cycle ignored
        step(0, 0, 16'h0100, 0, 1);
        step(0, 0, 0, 0, 1);
        // R6: return to User, then return on empty
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 1, 1);
        step(0, 0, 0, 0, 1);
        // R4/R5 nesting: stack interrupts, exception, then emulation
        step(0, 0, 16'h8010, 0, 0);
        step(0, 0, 16'h0008, 0, 1);
        step(0, 0, 16'h0001, 0, 1);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 1, 1);
        step(0, 0, 16'h0008, 1, 1); // R5 same-cycle re-set wins
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 1, 1);
        step(0, 0, 0, 0, 1);
        // R3: emulation-caused reset
        step(1, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 1, 1);
        step(0, 0, 0, 0, 1);
        // random phase
        for (int i = 0; i < 3000; i++) begin
            s = '0;
            if ($urandom_range(7) == 0) s[$urandom_range(W-1)] = 1'b1;
            if ($urandom_range(199) == 0) begin
                for (int k = 0; k < 1 + $urandom_range(2); k++)
                    step(1, $urandom_range(1) == 1, s, 1'b0, 1'b1);
            end else begin
                step(0, 0, s, $urandom_range(2) == 0, $urandom_range(3) == 0);
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule